// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Control

This block sits behind an external dual-modulus prescaler and turns the prescaler's output clock into a divided pulse train for a phase detector. A 10-bit main counter sets the length of each count cycle in rising edges of `fin`. A 6-bit swallow counter sets how many of those edges come at the start of the cycle with the modulus-control output low. For the rest of the cycle the modulus-control output is high, which selects the prescaler's other ratio.

At the end of each cycle both counters reload from the program inputs `n_prog` and `a_prog`. The block then raises `fv` for one `fin` period. Counting uses the rising edge of `fin` only. The asynchronous active-low reset loads both counters and holds both outputs low.

The program inputs are plain binary, with bit 0 as the least significant bit. At board level an unconnected program pin is assumed to be pulled to logic 1. The block samples the program inputs only when it reloads. Correct dual-modulus operation assumes `a_prog` ≤ `n_prog`.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `mc` and `fv` are 0. Leaving reset starts a count cycle with the counters loaded from `n_prog` and `a_prog`.
- R2: With a program value N ≥ 2, a count cycle lasts exactly N rising edges of `fin`. With N of 0 or 1, every rising edge ends a cycle.
- R3: In a cycle programmed with A < N, `mc` is 0 after the reload edge and after each of the next A−1 edges. It is 1 for the remaining N−A edge periods of the cycle.
- R4: If A ≥ N, `mc` stays 0 for the whole cycle.
- R5: If A = 0, `mc` is 1 for the whole cycle (the first cycle after reset starts with `mc` low).
- R6: `fv` is 1 for exactly one `fin` period, the one that follows the edge that ends a cycle. At all other times it is 0.
- R7: `n_prog` and `a_prog` are sampled only on the edge that ends a cycle. A change in the middle of a cycle leaves that cycle's length and `mc` pattern unchanged.
- R8: `n_prog[0]` and `a_prog[0]` are the least significant bits. The all-ones program (N=1023, A=63) gives a cycle of 1023 edges with `mc` low for the first 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin | input | 1 | Prescaler output clock; counting on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_prog | input | 10 | Main counter program value N, bit 0 LSB |
| a_prog | input | 6 | Swallow counter program value A, bit 0 LSB |
| mc | output | 1 | Modulus control to the prescaler |
| fv | output | 1 | Divided output pulse, one `fin` period wide |

## Verification
The bound checker checks three things on every edge: the main counter steps down by one until it reaches terminal count, `mc` agrees with whether the swallow counter is exhausted, and `fv` follows exactly the edges that end a cycle. Only the bench scenarios can show properties that depend on the program values. These are the exact cycle length for each N, the A ≥ N and A = 0 cases, and the fact that program changes in the middle of a cycle wait for the next reload. The scenarios also cover the all-ones and single-bit values that establish bit order.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
    localparam int MAIN_W_DEF = 10;
    localparam int SWAL_W_DEF = 6;

    typedef struct packed {
        logic mc;
        logic fv;
    } swallow_ctl_t;
endpackage

// File: rtl/swallow_main_count.sv
module swallow_main_count #(
    parameter int W = 10
) (
    input  logic         fin,
    input  logic         rst_n,
    input  logic [W-1:0] prog,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = (cnt_q <= ONE);
        cnt_d = wrap ? prog : cnt_q - ONE;
    end

    always_ff @(posedge fin or negedge rst_n) begin
        if (!rst_n) cnt_q <= prog;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/swallow_swal_count.sv
module swallow_swal_count #(
    parameter int W = 6
) (
    input  logic         fin,
    input  logic         rst_n,
    input  logic [W-1:0] prog,
    input  logic         reload,
    output logic [W-1:0] cnt,
    output logic         spent_d
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (reload)              cnt_d = prog;
        else if (cnt_q == ZERO)  cnt_d = ZERO;
        else                     cnt_d = cnt_q - W'(1);
        spent_d = (cnt_d == ZERO);
    end

    always_ff @(posedge fin or negedge rst_n) begin
        if (!rst_n) cnt_q <= prog;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swallow_pkg::*;
#(
    parameter int MAIN_W = MAIN_W_DEF,
    parameter int SWAL_W = SWAL_W_DEF
) (
    input  logic              fin,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] n_prog,
    input  logic [SWAL_W-1:0] a_prog,
    output logic              mc,
    output logic              fv
);
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swal_cnt;
    logic              wrap;
    logic              spent_d;
    swallow_ctl_t      ctl_d, ctl_q;

    swallow_main_count #(.W(MAIN_W)) u_main (
        .fin   (fin),
        .rst_n (rst_n),
        .prog  (n_prog),
        .cnt   (main_cnt),
        .wrap  (wrap)
    );

    swallow_swal_count #(.W(SWAL_W)) u_swal (
        .fin     (fin),
        .rst_n   (rst_n),
        .prog    (a_prog),
        .reload  (wrap),
        .cnt     (swal_cnt),
        .spent_d (spent_d)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.mc = spent_d;
        ctl_d.fv = wrap;
    end

    always_ff @(posedge fin or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mc = ctl_q.mc;
    assign fv = ctl_q.fv;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
    parameter int MAIN_W = 10,
    parameter int SWAL_W = 6
) (
    input logic              fin,
    input logic              rst_n,
    input logic              mc,
    input logic              fv,
    input logic [MAIN_W-1:0] main_cnt,
    input logic [SWAL_W-1:0] swal_cnt
);
    logic started_q;

    always_ff @(posedge fin or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge fin) !started_q |-> (!mc && !fv));

    // R2
    main_step_chk: assert property (@(posedge fin) disable iff (!rst_n)
        (started_q && $past(main_cnt) > MAIN_W'(1)) |-> (main_cnt == $past(main_cnt) - MAIN_W'(1)));

    // R3
    mc_low_while_swallow_chk: assert property (@(posedge fin) disable iff (!rst_n)
        (swal_cnt != '0) |-> !mc);

    // R3
    mc_high_when_spent_chk: assert property (@(posedge fin) disable iff (!rst_n)
        (started_q && swal_cnt == '0) |-> mc);

    // R6
    fv_on_wrap_chk: assert property (@(posedge fin) disable iff (!rst_n)
        started_q |-> (fv == ($past(main_cnt) <= MAIN_W'(1))));
endmodule

bind swallow_divider swallow_divider_chk #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_chk (
    .fin      (fin),
    .rst_n    (rst_n),
    .mc       (mc),
    .fv       (fv),
    .main_cnt (main_cnt),
    .swal_cnt (swal_cnt)
);

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;
    logic       fin = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] n_in = 10'd10;
    logic [5:0] a_in = 6'd3;
    logic       mc, fv;

    int checks = 0;
    int errors = 0;
    int cur_n, cur_a, pos;
    bit fresh;

    always #5 fin = ~fin;

    swallow_divider u_swallow_divider (
        .fin(fin), .rst_n(rst_n), .n_prog(n_in), .a_prog(a_in), .mc(mc), .fv(fv)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int n, input int a);
        @(negedge fin);
        rst_n = 1'b0;
        n_in  = 10'(n);
        a_in  = 6'(a);
        #2;
        // R1: outputs quiet in reset
        check_bit("R1", "mc in reset", mc, 1'b0);
        check_bit("R1", "fv in reset", fv, 1'b0);
        cur_n = n; cur_a = a; pos = 0; fresh = 1'b1;
        @(negedge fin);
        rst_n = 1'b1;
    endtask

    task automatic run_edges(input int count, input string req);
        for (int i = 0; i < count; i++) begin
            @(posedge fin);
            fresh = 1'b0;
            pos++;
            if (cur_n <= 1 || pos >= cur_n) begin
                pos   = 0;
                cur_n = int'(n_in);
                cur_a = int'(a_in);
            end
            @(negedge fin);
            check_bit(req, "mc", mc, (pos >= cur_a) ? 1'b1 : 1'b0);
            check_bit(req, "fv", fv, (pos == 0) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic t_basic();
        do_reset(10, 3);
        run_edges(35, "R2_R3_R6");
    endtask

    task automatic t_a_exceeds();
        do_reset(5, 9);
        run_edges(20, "R4");
    endtask

    task automatic t_a_zero();
        do_reset(7, 0);
        run_edges(22, "R5");
    endtask

    task automatic t_tiny();
        do_reset(1, 2);
        run_edges(6, "R2");
        do_reset(0, 0);
        run_edges(6, "R2");
        do_reset(2, 1);
        run_edges(8, "R2");
    endtask

    task automatic t_midchange();
        do_reset(12, 4);
        run_edges(5, "R7");
        n_in = 10'd6;
        a_in = 6'd2;
        run_edges(30, "R7");
    endtask

    task automatic t_bits();
        do_reset(1023, 63);
        run_edges(1100, "R8");
        do_reset(512, 1);
        run_edges(520, "R8");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_basic();
        t_a_exceeds();
        t_a_zero();
        t_tiny();
        t_midchange();
        t_bits();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule